// File: doc/BRIEF.md
# Banked burst-word unpacker

The block sits between several parallel memory bank streams and a fixed set of narrow element lanes. Each bank stream delivers wide words as tokens carrying a payload and a continue flag. When every bank has a word ready, the block takes one word from each bank in the same cycle. It then spends a fixed number of cycles slicing narrow elements out of that stored set and presenting one element on every output lane per cycle.

Elements are spread round-robin over the banks. Element `e` lives in bank `e mod NUM_BANKS`, at bit offset `(e div NUM_BANKS)*ELEM_W` within that bank's word. The number of cycles needed to drain one set of bank words is `C = BURST_W*NUM_BANKS / (LANES*ELEM_W)`. A steady stream is therefore consumed at one set of bank words every `C` cycles.

The continue flags of the banks combine into one group flag. Only the final slice of a group reports that flag, and a cleared flag ends the stream: the block then accepts no more words until it is reset.

The configuration must meet three conditions:
- `BURST_W*NUM_BANKS` is at least `LANES*ELEM_W`.
- `BURST_W*NUM_BANKS` is a whole multiple of `LANES*ELEM_W`.
- `BURST_W` is a whole multiple of `ELEM_W`.

Any configuration that breaks one of these is refused at elaboration.

Top module: `bank_word_unpacker`

## Requirements
- R1: After reset, no output lane is valid and no bank ready is raised while the banks offer nothing. The first group after reset starts at sub-cycle 0.
- R2: Words are taken from the banks only when every bank stream is valid. The ready signals of all banks are raised together, in the same cycle, or not at all.
- R3: Each stored set of bank words yields exactly C output beats. On every beat all lanes are valid together. No new words are taken while a beat is waiting on a lane.
- R4: In sub-cycle c (counting from 0), lane k carries element e = c*LANES + k. That element is bits [(e div NUM_BANKS)*ELEM_W +: ELEM_W] of the word from bank e mod NUM_BANKS. Lane k occupies bits [k*ELEM_W +: ELEM_W] of the output data bus, and bank b occupies bits [b*BURST_W +: BURST_W] of the input data bus.
- R5: On beats 0 to C-2 of a group, every lane's continue bit is 1. On beat C-1, every lane's continue bit equals the AND of the continue bits of all banks captured for that group.
- R6: Once a beat with continue bit 0 has been taken, no bank ready is raised again until reset and no further beat appears, even with every bank valid.
- R7: While any lane's ready is low, the presented beat keeps its data and continue bits unchanged. Every slice is delivered once, in order.
- R8: With all banks valid and all lanes ready, the next set of words is taken in the cycle of the last beat. Consecutive groups then come out as an unbroken run of beats, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_valid | input | NUM_BANKS | One bit per bank: a word is offered |
| bank_ready | output | NUM_BANKS | One bit per bank: the offered word is taken this cycle |
| bank_data | input | NUM_BANKS*BURST_W | Bank words, bank b at bits [b*BURST_W +: BURST_W] |
| bank_cont | input | NUM_BANKS | Continue flag of each bank token |
| lane_valid | output | LANES | One bit per lane: an element is presented |
| lane_ready | input | LANES | One bit per lane: the lane can accept |
| lane_data | output | LANES*ELEM_W | Elements, lane k at bits [k*ELEM_W +: ELEM_W] |
| lane_cont | output | LANES | Continue flag of each lane token |

## Verification
The first pattern is a single group whose byte values differ everywhere. It separates a correct bank/offset mapping from a swapped bank or a wrong element stride. Banks that become valid at different times show whether words are taken too early. A ready pattern that toggles per lane exposes skipped, repeated or drifting slices. A continuous run of groups shows whether a cycle is lost between groups. The last pattern is a group ended by one bank's cleared continue flag, which shows both the flag's placement on the final beat and the input staying closed afterwards.

// File: rtl/bwu_pkg.sv
package bwu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EMIT = 2'd1,
    ST_HALT = 2'd2
  } bwu_state_e;

  // Bit position, within the flat set of bank words, of a given element.
  function automatic int elem_base(int e, int nb, int bw, int ew);
    return (e % nb) * bw + (e / nb) * ew;
  endfunction

endpackage

// File: rtl/bwu_ctrl.sv
module bwu_ctrl #(
  parameter int NB    = 2,
  parameter int C_SUB = 4,
  parameter int SUB_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NB-1:0]    bank_valid,
  input  logic             grp_cont_in,
  input  logic             lanes_ready,
  output logic             load,
  output logic             full,
  output logic             last,
  output logic             cont_q,
  output logic [SUB_W-1:0] sub_q
);
  import bwu_pkg::*;

  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(C_SUB - 1);

  bwu_state_e       state_q, state_d;
  logic [SUB_W-1:0] sub_d;
  logic             cont_d;
  logic             all_valid;
  logic             fire;

  assign all_valid = &bank_valid;
  assign full      = (state_q == ST_EMIT);
  assign last      = (sub_q == SUB_LAST);
  assign fire      = full && lanes_ready;

  always_comb begin
    load = 1'b0;
    case (state_q)
      ST_IDLE: load = all_valid;
      ST_EMIT: load = fire && last && cont_q && all_valid;
      default: load = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (load) state_d = ST_EMIT;
      ST_EMIT: begin
        if (fire && last) begin
          if (!cont_q)   state_d = ST_HALT;
          else if (load) state_d = ST_EMIT;
          else           state_d = ST_IDLE;
        end
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_comb begin
    sub_d = sub_q;
    if (load)      sub_d = '0;
    else if (fire) sub_d = last ? '0 : sub_q + SUB_W'(1);
  end

  always_comb begin
    cont_d = cont_q;
    if (load) cont_d = grp_cont_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sub_q   <= '0;
      cont_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sub_q   <= sub_d;
      cont_q  <= cont_d;
    end
  end

  assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT) |=> (state_q == ST_HALT) && !load);

  assert_sub_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_q <= SUB_LAST));

endmodule

// File: rtl/bwu_word_buf.sv
module bwu_word_buf #(
  parameter int NB = 2,
  parameter int BW = 32
) (
  input  logic             clk,
  input  logic             load,
  input  logic [NB*BW-1:0] d,
  output logic [NB*BW-1:0] q
);
  // Payload storage: no reset, written only under its clock enable.
  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (load) q[b*BW +: BW] <= d[b*BW +: BW];
    end
  end
endmodule

// File: rtl/bwu_lane_slice.sv
module bwu_lane_slice #(
  parameter int LANE  = 0,
  parameter int LANES = 2,
  parameter int NB    = 2,
  parameter int BW    = 32,
  parameter int EW    = 8,
  parameter int C_SUB = 4,
  parameter int SUB_W = 2
) (
  input  logic [NB*BW-1:0] words,
  input  logic [SUB_W-1:0] sub,
  output logic [EW-1:0]    elem
);
  always_comb begin
    elem = '0;
    for (int c = 0; c < C_SUB; c++) begin
      if (sub == SUB_W'(c))
        elem = words[bwu_pkg::elem_base(c*LANES + LANE, NB, BW, EW) +: EW];
    end
  end
endmodule

// File: rtl/bank_word_unpacker.sv
module bank_word_unpacker #(
  parameter int BURST_W   = 32,
  parameter int NUM_BANKS = 2,
  parameter int LANES     = 2,
  parameter int ELEM_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_BANKS-1:0]         bank_valid,
  output logic [NUM_BANKS-1:0]         bank_ready,
  input  logic [NUM_BANKS*BURST_W-1:0] bank_data,
  input  logic [NUM_BANKS-1:0]         bank_cont,
  output logic [LANES-1:0]             lane_valid,
  input  logic [LANES-1:0]             lane_ready,
  output logic [LANES*ELEM_W-1:0]      lane_data,
  output logic [LANES-1:0]             lane_cont
);
  localparam int GROUP_W = LANES * ELEM_W;
  localparam int SET_W   = BURST_W * NUM_BANKS;
  localparam int C_SUB   = (SET_W >= GROUP_W) ? SET_W / GROUP_W : 1;
  localparam int SUB_W   = (C_SUB > 1) ? $clog2(C_SUB) : 1;

  if (SET_W < GROUP_W || (SET_W % GROUP_W) != 0 || (BURST_W % ELEM_W) != 0) begin : g_bad_cfg
    $error("bank_word_unpacker: unsupported width configuration");
  end

  logic                 load, full, last, cont_q;
  logic [SUB_W-1:0]     sub_q;
  logic [SET_W-1:0]     words_q;

  bwu_ctrl #(.NB(NUM_BANKS), .C_SUB(C_SUB), .SUB_W(SUB_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .bank_valid  (bank_valid),
    .grp_cont_in (&bank_cont),
    .lanes_ready (&lane_ready),
    .load        (load),
    .full        (full),
    .last        (last),
    .cont_q      (cont_q),
    .sub_q       (sub_q)
  );

  bwu_word_buf #(.NB(NUM_BANKS), .BW(BURST_W)) u_buf (
    .clk  (clk),
    .load (load),
    .d    (bank_data),
    .q    (words_q)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    bwu_lane_slice #(
      .LANE(k), .LANES(LANES), .NB(NUM_BANKS), .BW(BURST_W),
      .EW(ELEM_W), .C_SUB(C_SUB), .SUB_W(SUB_W)
    ) u_slice (
      .words (words_q),
      .sub   (sub_q),
      .elem  (lane_data[k*ELEM_W +: ELEM_W])
    );
    assign lane_cont[k]  = last ? cont_q : 1'b1;
    assign lane_valid[k] = full;
  end

  assign bank_ready = {NUM_BANKS{load}};

  assert_ready_needs_all_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_ready) |-> (&bank_valid));

  assert_ready_together_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_ready == '0) || (&bank_ready));

  assert_no_take_on_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|lane_valid) && !(&lane_ready)) |-> (bank_ready == '0));

  assert_hold_on_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|lane_valid) && !(&lane_ready)) |=>
      ((&lane_valid) && $stable(lane_data) && $stable(lane_cont)));

  assert_end_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|lane_valid) && (&lane_ready) && !lane_cont[0]) |=>
      ((lane_valid == '0) && (bank_ready == '0)));

endmodule

// File: tb/bank_word_unpacker_tb.sv
module bank_word_unpacker_tb;
  localparam int BW = 32;
  localparam int NB = 2;
  localparam int LN = 2;
  localparam int EW = 8;
  localparam int C  = (BW*NB) / (LN*EW);
  localparam int DW = NB*BW;
  localparam int OW = LN*EW;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic [NB-1:0] bank_valid, bank_ready, bank_cont;
  logic [DW-1:0] bank_data;
  logic [LN-1:0] lane_valid, lane_ready, lane_cont;
  logic [OW-1:0] lane_data;

  bank_word_unpacker #(.BURST_W(BW), .NUM_BANKS(NB), .LANES(LN), .ELEM_W(EW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .bank_valid(bank_valid), .bank_ready(bank_ready),
    .bank_data(bank_data), .bank_cont(bank_cont),
    .lane_valid(lane_valid), .lane_ready(lane_ready),
    .lane_data(lane_data), .lane_cont(lane_cont)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int beats = 0;
  int pops = 0;
  logic [OW-1:0] bdata [0:255];
  logic [LN-1:0] bcont [0:255];
  int            btime [0:255];

  // Transfers are seen at the falling edge; they complete at the next rise.
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if ((&lane_valid) && (&lane_ready) && beats < 256) begin
        bdata[beats] = lane_data;
        bcont[beats] = lane_cont;
        btime[beats] = cyc;
        beats = beats + 1;
      end
      if ((&bank_valid) && (|bank_ready)) pops = pops + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [OW-1:0] exp_beat(logic [DW-1:0] w, int c);
    logic [OW-1:0] r;
    for (int k = 0; k < LN; k++) begin
      int e;
      e = c*LN + k;
      r[k*EW +: EW] = w[(e % NB)*BW + (e / NB)*EW +: EW];
    end
    return r;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; bank_valid = '0; bank_data = '0; bank_cont = '0; lane_ready = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
  endtask

  // Offer one set of bank words and wait until it is taken.
  task automatic offer(input logic [DW-1:0] w, input logic [NB-1:0] ct);
    int p0;
    p0 = pops;
    bank_data = w; bank_cont = ct; bank_valid = '1;
    for (int i = 0; i < 50 && pops == p0; i++) @(negedge clk);
    @(posedge clk); #2 bank_valid = '0;
  endtask

  task automatic check_group(input string req, input int b0, input logic [DW-1:0] w,
                             input logic last_cont);
    for (int c = 0; c < C; c++) begin
      chk({req, " R4 beat data"}, 64'(bdata[b0+c]), 64'(exp_beat(w, c)));
      chk({req, " R5 beat cont"}, 64'(bcont[b0+c]),
          64'((c == C-1) ? {LN{last_cont}} : {LN{1'b1}}));
    end
  endtask

  task automatic t_reset_R1();
    do_reset();
    @(negedge clk);
    chk("R1 lane_valid after reset", 64'(lane_valid), 64'(0));
    chk("R1 bank_ready after reset", 64'(bank_ready), 64'(0));
  endtask

  task automatic t_single_R3();
    int b0;
    logic [DW-1:0] w;
    w = 64'h1122334455667788;
    b0 = beats;
    @(posedge clk); #2 lane_ready = '1;
    offer(w, '1);
    repeat (C + 3) @(negedge clk);
    chk("R3 beat count for one group", 64'(beats - b0), 64'(C));
    check_group("R3 single", b0, w, 1'b1);
  endtask

  task automatic t_wait_banks_R2();
    int p0, b0;
    logic [DW-1:0] w;
    w = 64'hA0A1A2A3B0B1B2B3;
    p0 = pops; b0 = beats;
    @(posedge clk); #2 bank_data = w; bank_cont = '1; bank_valid = 2'b01;
    repeat (5) begin
      @(negedge clk);
      chk("R2 no ready with one bank missing", 64'(bank_ready), 64'(0));
    end
    chk("R2 no pop with one bank missing", 64'(pops - p0), 64'(0));
    @(posedge clk); #2 bank_valid = 2'b11;
    @(negedge clk);
    chk("R2 all readies together", 64'(bank_ready), 64'({NB{1'b1}}));
    @(posedge clk); #2 bank_valid = '0;
    repeat (C + 2) @(negedge clk);
    chk("R2 one pop", 64'(pops - p0), 64'(1));
    check_group("R2 late bank", b0, w, 1'b1);
  endtask

  task automatic t_stall_R7();
    int b0;
    logic [DW-1:0] w;
    logic [OW-1:0] held;
    logic          stalled;
    logic [15:0]   pat;
    w = 64'hDEADBEEFCAFEF00D;
    pat = 16'b1101_0110_0101_1010;
    b0 = beats; stalled = 1'b0; held = '0;
    @(posedge clk); #2 lane_ready = '0;
    offer(w, '1);
    for (int i = 0; i < 16; i++) begin
      @(posedge clk); #2 lane_ready = pat[i] ? 2'b11 : ((i % 2 == 0) ? 2'b01 : 2'b10);
      @(negedge clk);
      if (stalled && (&lane_valid))
        chk("R7 data held while stalled", 64'(lane_data), 64'(held));
      stalled = (&lane_valid) && !(&lane_ready);
      held = lane_data;
    end
    @(posedge clk); #2 lane_ready = '1;
    repeat (C + 2) @(negedge clk);
    chk("R7 no skip or repeat", 64'(beats - b0), 64'(C));
    check_group("R7 stall", b0, w, 1'b1);
  endtask

  task automatic t_back_to_back_R8();
    int b0;
    logic [DW-1:0] w [0:2];
    w[0] = 64'h0102030405060708;
    w[1] = 64'h1F2E3D4C5B6A7988;
    w[2] = 64'hF0E1D2C3B4A59687;
    b0 = beats;
    @(posedge clk); #2 lane_ready = '1;
    for (int g = 0; g < 3; g++) begin
      int p0;
      p0 = pops;
      bank_data = w[g]; bank_cont = '1; bank_valid = '1;
      for (int i = 0; i < 50 && pops == p0; i++) @(negedge clk);
      @(posedge clk); #2;
    end
    bank_valid = '0;
    repeat (C + 3) @(negedge clk);
    chk("R8 beat count for three groups", 64'(beats - b0), 64'(3*C));
    for (int i = 1; i < 3*C; i++)
      chk("R8 no gap between beats", 64'(btime[b0+i] - btime[b0+i-1]), 64'(1));
    for (int g = 0; g < 3; g++) check_group("R8 run", b0 + g*C, w[g], 1'b1);
  endtask

  task automatic t_end_R6();
    int b0, p0;
    logic [DW-1:0] w;
    w = 64'h89ABCDEF01234567;
    b0 = beats;
    @(posedge clk); #2 lane_ready = '1;
    offer(w, 2'b10);
    repeat (C + 2) @(negedge clk);
    check_group("R6 end group", b0, w, 1'b0);
    p0 = pops; b0 = beats;
    @(posedge clk); #2 bank_data = ~w; bank_cont = '1; bank_valid = '1;
    repeat (10) begin
      @(negedge clk);
      chk("R6 ready stays low after end", 64'(bank_ready), 64'(0));
    end
    chk("R6 no pop after end", 64'(pops - p0), 64'(0));
    chk("R6 no beat after end", 64'(beats - b0), 64'(0));
    @(posedge clk); #2 bank_valid = '0;
    do_reset();
    b0 = beats;
    @(posedge clk); #2 lane_ready = '1;
    offer(w, '1);
    repeat (C + 2) @(negedge clk);
    chk("R1 accepts again after reset", 64'(beats - b0), 64'(C));
    check_group("R1 restart from sub-cycle 0", b0, w, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_R1();
    t_single_R3();
    t_wait_banks_R2();
    t_stall_R7();
    t_back_to_back_R8();
    t_end_R6();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule